// File: doc/BRIEF.md
# CPU Exception Priority Arbiter

This block chooses which exception a small CPU core enters. Every cycle it collects the requests that may be taken at once: the reset pin, a watchdog overflow, an illegal opcode flag and a trap instruction. On an instruction-retire strobe it also weighs the requests that may only be taken between instructions: trace, direct transition out of sleep, and a pending interrupt. It picks the highest-priority request, pulses a start strobe for one cycle, and holds a one-hot select and a vector number for the exception sequencer until that sequencer acknowledges.

Some instructions block acceptance. An interrupt is not taken at the retire boundary of an instruction that rewrites the condition or extended flags, and not at the first boundary after reset handling. Trace works only in interrupt control mode 2 and never right after a return-from-exception. Pulse requests that lose arbitration stay latched until their own exception is acknowledged. A reset grant discards them.

Top module: `cpu_exc_arbiter`

## Requirements
- R1: Priority, highest first: reset, illegal instruction, trace, direct transition, interrupt, trap. The select bit positions are reset 0, illegal 1, trace 2, direct 3, interrupt 4, trap 5. The default vectors are 0, 4, 5, 6, 16 and 8 in the same order.
- R2: While `res_n` is low, `exc_start`, `exc_sel` and `exc_vec` are zero. The first clock edge with `res_n` high issues a reset exception.
- R3: A `wdt_ovf` pulse issues a reset exception. Granting a reset discards any latched illegal, direct-transition or trap request.
- R4: Illegal-opcode and trap requests are granted without a retire strobe, in the cycle after they arrive, when no exception is in progress.
- R5: Trace is granted at a retire strobe only when `trace_bit` is 1, `icm` is 2, and `ret_op` is not 5 (return from exception).
- R6: An interrupt is not granted at a retire strobe whose `ret_op` is 1, 2, 3 or 4 (flag-register logic and load instructions). It is also not granted at the first retire strobe after a reset exception is acknowledged.
- R7: Trace, direct transition and interrupt are granted only at a retire strobe. A `dt_req` that arrives without one stays latched until the next strobe.
- R8: `exc_start` lasts one cycle. `exc_sel` is one-hot with the matching `exc_vec`, held until `exc_ack`. No further grant happens while an exception is in progress.
- R9: A latched request that loses, or that arrives while another exception is in progress, is granted one cycle after the cycle in which `exc_ack` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| res_n | input | 1 | Reset pin, active low, asynchronous |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| ill_op | input | 1 | Illegal opcode detected pulse |
| trace_bit | input | 1 | Trace enable bit from the extended status |
| icm | input | 2 | Interrupt control mode |
| dt_req | input | 1 | Sleep direct-transition request pulse |
| irq_req | input | 1 | Interrupt pending level from the interrupt controller |
| trap_req | input | 1 | Trap instruction request pulse |
| ret_op | input | 3 | Class of the retiring instruction: 0 other, 1-4 flag/load ops, 5 return from exception |
| ret_vld | input | 1 | Instruction retire strobe |
| exc_ack | input | 1 | Sequencer done with the current exception |
| exc_start | output | 1 | One-cycle start pulse |
| exc_sel | output | 6 | One-hot exception select |
| exc_vec | output | VW | Vector number of the selected exception |

## Verification
Every grant is registered once. A request present before clock edge N shows as `exc_start` with its select and vector just after edge N. A request that waits for an acknowledge appears one edge after the edge that sampled `exc_ack`. The bench drives inputs on the falling edge and checks outputs on the next falling edge, which puts each check after exactly one rising edge. After each acknowledge it runs one idle retire cycle, and checks that no leftover request starts there. The reset-pin checks are made while the pin is low, because those outputs clear asynchronously.

// File: rtl/cpu_exc_arbiter.sv
module cpu_exc_arbiter #(
  parameter int VW       = 8,
  parameter int VEC_RST  = 0,
  parameter int VEC_ILL  = 4,
  parameter int VEC_TRC  = 5,
  parameter int VEC_DT   = 6,
  parameter int VEC_IRQ  = 16,
  parameter int VEC_TRAP = 8
) (
  input  logic          clk,
  input  logic          res_n,
  input  logic          wdt_ovf,
  input  logic          ill_op,
  input  logic          trace_bit,
  input  logic [1:0]    icm,
  input  logic          dt_req,
  input  logic          irq_req,
  input  logic          trap_req,
  input  logic [2:0]    ret_op,
  input  logic          ret_vld,
  input  logic          exc_ack,
  output logic          exc_start,
  output logic [5:0]    exc_sel,
  output logic [VW-1:0] exc_vec
);

  localparam logic [2:0] OP_RTE = 3'd5;

  logic p_rst, p_ill, p_dt, p_trap, busy, after_rst;
  logic [5:0] cand, grant;
  logic [VW-1:0] gvec;

  wire trc_ok = ret_vld && trace_bit && (icm == 2'd2) && (ret_op != OP_RTE);
  wire irq_blk = (ret_op >= 3'd1) && (ret_op <= 3'd4);
  wire irq_ok = ret_vld && irq_req && !irq_blk && !after_rst;
  wire dt_ok = ret_vld && (p_dt || dt_req);

  assign cand  = {p_trap | trap_req, irq_ok, dt_ok, trc_ok, p_ill | ill_op, p_rst | wdt_ovf};
  assign grant = busy ? 6'b0 : (cand & (~cand + 6'd1));

  always_comb begin
    case (grant)
      6'b000001: gvec = VW'(VEC_RST);
      6'b000010: gvec = VW'(VEC_ILL);
      6'b000100: gvec = VW'(VEC_TRC);
      6'b001000: gvec = VW'(VEC_DT);
      6'b010000: gvec = VW'(VEC_IRQ);
      6'b100000: gvec = VW'(VEC_TRAP);
      default:   gvec = '0;
    endcase
  end

  always_ff @(posedge clk or negedge res_n) begin
    if (!res_n) begin
      p_rst     <= 1'b1;
      p_ill     <= 1'b0;
      p_dt      <= 1'b0;
      p_trap    <= 1'b0;
      busy      <= 1'b0;
      after_rst <= 1'b0;
      exc_start <= 1'b0;
      exc_sel   <= '0;
      exc_vec   <= '0;
    end else begin
      exc_start <= |grant;
      p_rst  <= p_rst | wdt_ovf;
      p_ill  <= (p_ill | ill_op) & ~grant[0];
      p_dt   <= (p_dt | dt_req) & ~grant[0];
      p_trap <= (p_trap | trap_req) & ~grant[0];
      if (ret_vld && !busy) after_rst <= 1'b0;
      if (busy && exc_ack) begin
        busy    <= 1'b0;
        exc_sel <= '0;
        exc_vec <= '0;
        if (exc_sel[0]) begin
          p_rst     <= 1'b0;
          after_rst <= 1'b1;
        end
        if (exc_sel[1]) p_ill  <= 1'b0;
        if (exc_sel[3]) p_dt   <= 1'b0;
        if (exc_sel[5]) p_trap <= 1'b0;
      end else if (|grant) begin
        busy    <= 1'b1;
        exc_sel <= grant;
        exc_vec <= gvec;
      end
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!res_n) $onehot0(exc_sel)); // R8
  AST_START_HAS_SEL: assert property (@(posedge clk) disable iff (!res_n) exc_start |-> $countones(exc_sel) == 1); // R8
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!res_n) exc_start |=> !exc_start); // R8
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!res_n) ((|exc_sel) && !exc_ack) |=> ($stable(exc_sel) && $stable(exc_vec))); // R8
  AST_TRACE_GATE: assert property (@(posedge clk) disable iff (!res_n)
    (exc_start && exc_sel[2]) |-> ($past(ret_vld) && $past(trace_bit) && $past(icm) == 2'd2 && $past(ret_op) != OP_RTE)); // R5
  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!res_n)
    (exc_start && exc_sel[4]) |-> ($past(ret_vld) && ($past(ret_op) == 3'd0 || $past(ret_op) > 3'd4))); // R6

endmodule

// File: tb/cpu_exc_arbiter_bench.sv
`timescale 1ns/1ps
module cpu_exc_arbiter_bench;
  logic clk = 1'b0;
  logic res_n, wdt_ovf, ill_op, trace_bit, dt_req, irq_req, trap_req, ret_vld, exc_ack;
  logic [1:0] icm;
  logic [2:0] ret_op;
  logic exc_start;
  logic [5:0] exc_sel;
  logic [7:0] exc_vec;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cpu_exc_arbiter u_cpu_exc_arbiter (
    .clk(clk), .res_n(res_n), .wdt_ovf(wdt_ovf), .ill_op(ill_op), .trace_bit(trace_bit),
    .icm(icm), .dt_req(dt_req), .irq_req(irq_req), .trap_req(trap_req), .ret_op(ret_op),
    .ret_vld(ret_vld), .exc_ack(exc_ack), .exc_start(exc_start), .exc_sel(exc_sel), .exc_vec(exc_vec)
  );

  // row: {wdt, ill, tbit, icm[1:0], dt, irq, trap, op[2:0], vld, exp_sel[5:0]}
  localparam logic [17:0] VT [0:15] = '{
    {1'b0,1'b0,1'b0,2'd0,1'b0,1'b1,1'b0,3'd0,1'b1,6'b010000}, // R6 irq normal
    {1'b0,1'b0,1'b0,2'd0,1'b0,1'b1,1'b0,3'd1,1'b1,6'b000000}, // R6 op 1
    {1'b0,1'b0,1'b0,2'd0,1'b0,1'b1,1'b0,3'd4,1'b1,6'b000000}, // R6 op 4
    {1'b0,1'b0,1'b0,2'd0,1'b0,1'b1,1'b0,3'd0,1'b0,6'b000000}, // R7 no strobe
    {1'b0,1'b0,1'b1,2'd2,1'b0,1'b0,1'b0,3'd0,1'b1,6'b000100}, // R5 trace
    {1'b0,1'b0,1'b1,2'd0,1'b0,1'b0,1'b0,3'd0,1'b1,6'b000000}, // R5 wrong mode
    {1'b0,1'b0,1'b1,2'd2,1'b0,1'b0,1'b0,3'd5,1'b1,6'b000000}, // R5 after RTE
    {1'b0,1'b0,1'b1,2'd2,1'b0,1'b1,1'b0,3'd5,1'b1,6'b010000}, // R1 irq after RTE
    {1'b0,1'b0,1'b0,2'd0,1'b1,1'b0,1'b0,3'd0,1'b1,6'b001000}, // R7 dt
    {1'b0,1'b0,1'b0,2'd0,1'b1,1'b1,1'b0,3'd0,1'b1,6'b001000}, // R1 dt over irq
    {1'b0,1'b0,1'b1,2'd2,1'b0,1'b1,1'b0,3'd0,1'b1,6'b000100}, // R1 trace over irq
    {1'b0,1'b1,1'b0,2'd0,1'b0,1'b1,1'b0,3'd0,1'b1,6'b000010}, // R1 illegal over irq
    {1'b0,1'b0,1'b0,2'd0,1'b0,1'b0,1'b1,3'd0,1'b0,6'b100000}, // R4 trap
    {1'b1,1'b0,1'b0,2'd0,1'b0,1'b0,1'b0,3'd0,1'b0,6'b000001}, // R3 watchdog
    {1'b0,1'b1,1'b1,2'd2,1'b0,1'b0,1'b0,3'd0,1'b1,6'b000010}, // R1 illegal over trace
    {1'b1,1'b1,1'b0,2'd0,1'b0,1'b0,1'b0,3'd0,1'b0,6'b000001}  // R3 reset drops illegal
  };

  function automatic logic [7:0] ev(input logic [5:0] s);
    case (s)
      6'b000001: return 8'd0;
      6'b000010: return 8'd4;
      6'b000100: return 8'd5;
      6'b001000: return 8'd6;
      6'b010000: return 8'd16;
      6'b100000: return 8'd8;
      default:   return 8'd0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [14:0] act, input logic [14:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got start/sel/vec %h expected %h", req, act, exp);
    end
  endtask

  task automatic expect_out(input string req, input logic st, input logic [5:0] s);
    chk(req, {st, exc_sel, exc_vec}, {st, s, ev(s)});
  endtask

  task automatic clr();
    wdt_ovf = 0; ill_op = 0; trace_bit = 0; icm = 0; dt_req = 0;
    irq_req = 0; trap_req = 0; ret_op = 0; ret_vld = 0; exc_ack = 0;
  endtask

  task automatic ack_cycle();
    exc_ack = 1; @(negedge clk); exc_ack = 0;
  endtask

  initial begin
    res_n = 0; clr();
    repeat (3) @(negedge clk);
    expect_out("R2 held in reset", 1'b0, 6'b0);
    res_n = 1;
    @(negedge clk);
    expect_out("R2 reset on release", 1'b1, 6'b000001);
    @(negedge clk);
    expect_out("R8 start one cycle, sel held", 1'b0, 6'b000001);
    ack_cycle();
    expect_out("R8 cleared by ack", 1'b0, 6'b0);
    irq_req = 1; ret_vld = 1;
    @(negedge clk);
    expect_out("R6 irq blocked after reset handling", 1'b0, 6'b0);
    @(negedge clk);
    expect_out("R6 irq at next boundary", 1'b1, 6'b010000);
    clr(); ack_cycle();

    for (int i = 0; i < 16; i++) begin
      logic [17:0] r;
      r = VT[i];
      {wdt_ovf, ill_op, trace_bit, icm, dt_req, irq_req, trap_req, ret_op, ret_vld} = r[17:6];
      @(negedge clk);
      expect_out($sformatf("R1 table row %0d", i), r[5:0] != 0, r[5:0]);
      clr();
      if (r[5:0] != 0) ack_cycle();
      ret_vld = 1;
      @(negedge clk);
      ret_vld = 0;
      expect_out($sformatf("R3 R9 nothing left after row %0d", i), 1'b0, 6'b0);
    end

    dt_req = 1;
    @(negedge clk);
    dt_req = 0;
    expect_out("R7 dt waits for strobe", 1'b0, 6'b0);
    @(negedge clk);
    expect_out("R7 dt still waiting", 1'b0, 6'b0);
    ret_vld = 1;
    @(negedge clk);
    ret_vld = 0;
    expect_out("R7 latched dt at strobe", 1'b1, 6'b001000);
    ack_cycle();

    trap_req = 1; irq_req = 1; ret_vld = 1;
    @(negedge clk);
    clr();
    expect_out("R1 irq beats trap", 1'b1, 6'b010000);
    ill_op = 1;
    @(negedge clk);
    ill_op = 0;
    expect_out("R8 no grant while busy", 1'b0, 6'b010000);
    ack_cycle();
    expect_out("R9 nothing in ack cycle", 1'b0, 6'b0);
    @(negedge clk);
    expect_out("R9 illegal after ack", 1'b1, 6'b000010);
    ack_cycle();
    @(negedge clk);
    expect_out("R9 trap still pending", 1'b1, 6'b100000);
    ack_cycle();

    ill_op = 1;
    @(negedge clk);
    ill_op = 0;
    expect_out("R4 illegal without strobe", 1'b1, 6'b000010);
    res_n = 0;
    #1;
    expect_out("R2 outputs clear on pin low", 1'b0, 6'b0);
    @(negedge clk);
    res_n = 1;
    @(negedge clk);
    expect_out("R2 reset after second release", 1'b1, 6'b000001);
    ack_cycle();
    @(negedge clk);
    expect_out("R3 illegal dropped by pin reset", 1'b0, 6'b0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule